// File: doc/BRIEF.md
# Packed 52-bit Multiply-Accumulate Unit

This block is a pipelined SIMD datapath that splits each of its vector operands into independent 64-bit lanes. Within a lane it takes the low 52 bits of two source operands as unsigned integers and multiplies them into a 104-bit product. It then adds either the lower or the upper 52-bit half of that product, zero-extended, to the 64-bit accumulator lane. The sum wraps modulo 2^64.

A per-lane enable mask decides which lanes take the new sum. A lane that is not enabled either keeps its accumulator value (merge) or is forced to zero (zeroing), chosen per operation. One operation can be accepted on every clock. Each accepted operation produces a matching valid result after a fixed latency set by a parameter.

The unit is used as the arithmetic core for wide-integer arithmetic built from 52-bit limbs, such as modular exponentiation. The low-half and high-half operations together give the full product of two limbs.

Top module: `pmac52_unit`

## Requirements
- R1: Every 64-bit lane `k` (bits `64*k+63 : 64*k` of each vector, with mask bit `k`) is computed only from its own lane of the inputs.
- R2: Bits 63:52 of each source lane have no effect on the result.
- R3: With `hi_sel` = 0, an enabled lane returns `acc + {12'b0, P[51:0]}`, where `P` is the 104-bit product of the two 52-bit source fields.
- R4: With `hi_sel` = 1, an enabled lane returns `acc + {12'b0, P[103:52]}`.
- R5: The lane addition wraps modulo 2^64. There is no saturation and no carry-out.
- R6: With `zero_off` = 0, a lane whose `lane_en` bit is 0 returns its accumulator lane unchanged.
- R7: With `zero_off` = 1, a lane whose `lane_en` bit is 0 returns zero.
- R8: An operation presented with `in_valid` = 1 at a rising edge shows up with `out_valid` = 1 exactly `LATENCY` rising edges later, counting that edge. Back-to-back operations are accepted on every cycle, and `out_valid` is 0 when no operation is due.
- R9: While `rst_n` is low, and directly after it rises, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| hi_sel | input | 1 | 0: accumulate product bits 51:0; 1: accumulate bits 103:52 |
| zero_off | input | 1 | 0: disabled lanes keep the accumulator; 1: disabled lanes become zero |
| lane_en | input | LANES | Per-lane write enable |
| src_a | input | 64*LANES | First multiplicand vector |
| src_b | input | 64*LANES | Second multiplicand vector |
| acc_in | input | 64*LANES | Accumulator vector |
| out_valid | output | 1 | Result strobe |
| result | output | 64*LANES | Updated accumulator vector |

## Verification
The bench builds the unit with three lanes and a latency of two. The odd, non-power-of-two lane count exposes lane-slicing mistakes at the vector's top edge. The short pipeline puts gapped and back-to-back strobes within a few cycles of each other, so a latency that is off by one shows up. A reference model computes 128-bit products and covers several cases: all-ones 52-bit fields, zero operands, garbage in the upper 12 bits, accumulators that wrap, and every mix of mask, half-select and zeroing. Random vectors then fill in the remaining combinations.

// File: rtl/pmac52_pkg.sv
package pmac52_pkg;
   localparam int LANE_W = 64;
   localparam int OP_W   = 52;
   localparam int PROD_W = 2 * OP_W;
   localparam int PAD_W  = LANE_W - OP_W;

   typedef logic [LANE_W-1:0] lane_t;
   typedef logic [OP_W-1:0]   limb_t;
   typedef logic [PROD_W-1:0] prod_t;

   typedef struct packed {
      logic hi;
      logic zero;
   } ctl_t;
endpackage

// File: rtl/pmac52_lane.sv
module pmac52_lane
   import pmac52_pkg::*;
(
   input  limb_t a,
   input  limb_t b,
   input  lane_t acc,
   input  ctl_t  ctl,
   input  logic  en,
   output lane_t res
);
   prod_t prod;
   limb_t half;
   lane_t sum;

   always_comb begin
      prod = prod_t'(a) * prod_t'(b);
      half = ctl.hi ? prod[PROD_W-1:OP_W] : prod[OP_W-1:0];
      sum  = acc + {{PAD_W{1'b0}}, half};
      if (en)
         res = sum;
      else if (ctl.zero)
         res = '0;
      else
         res = acc;
   end
endmodule

// File: rtl/pmac52_delay.sv
module pmac52_delay #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [WIDTH-1:0] stage [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
            end else begin
               stage[0] <= d;
               for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
            end
         end
         assign q = stage[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/pmac52_unit.sv
module pmac52_unit
   import pmac52_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int LATENCY = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    hi_sel,
   input  logic                    zero_off,
   input  logic [LANES-1:0]        lane_en,
   input  logic [LANES*LANE_W-1:0] src_a,
   input  logic [LANES*LANE_W-1:0] src_b,
   input  logic [LANES*LANE_W-1:0] acc_in,
   output logic                    out_valid,
   output logic [LANES*LANE_W-1:0] result
);
   localparam int VEC_W  = LANES * LANE_W;
   localparam int LIMB_V = LANES * OP_W;
   localparam int TAIL   = LATENCY - 1;
   localparam int PIPE_W = VEC_W + 1;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("pmac52_unit: LANES must be at least 1");
      end
      if (LATENCY < 1) begin : g_bad_lat
         $error("pmac52_unit: LATENCY must be at least 1");
      end
   endgenerate

   // input stage: only the 52-bit fields are kept
   logic               s1_valid;
   ctl_t               s1_ctl;
   logic [LANES-1:0]   s1_en;
   logic [LIMB_V-1:0]  s1_a;
   logic [LIMB_V-1:0]  s1_b;
   logic [VEC_W-1:0]   s1_acc;
   logic [LIMB_V-1:0]  a_fields;
   logic [LIMB_V-1:0]  b_fields;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_strip
         assign a_fields[k*OP_W +: OP_W] = src_a[k*LANE_W +: OP_W];
         assign b_fields[k*OP_W +: OP_W] = src_b[k*LANE_W +: OP_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_ctl   <= '0;
         s1_en    <= '0;
         s1_a     <= '0;
         s1_b     <= '0;
         s1_acc   <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_ctl   <= '{hi: hi_sel, zero: zero_off};
         s1_en    <= lane_en;
         s1_a     <= a_fields;
         s1_b     <= b_fields;
         s1_acc   <= acc_in;
      end
   end

   logic [VEC_W-1:0] lane_res;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         pmac52_lane u_lane (
            .a   (s1_a[k*OP_W +: OP_W]),
            .b   (s1_b[k*OP_W +: OP_W]),
            .acc (s1_acc[k*LANE_W +: LANE_W]),
            .ctl (s1_ctl),
            .en  (s1_en[k]),
            .res (lane_res[k*LANE_W +: LANE_W])
         );
      end
   endgenerate

   logic [PIPE_W-1:0] pipe_q;

   pmac52_delay #(
      .WIDTH (PIPE_W),
      .DEPTH (TAIL)
   ) u_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({s1_valid, lane_res}),
      .q     (pipe_q)
   );

   assign out_valid = pipe_q[PIPE_W-1];
   assign result    = pipe_q[VEC_W-1:0];
endmodule

// File: rtl/pmac52_chk.sv
module pmac52_chk
   import pmac52_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int LATENCY = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    hi_sel,
   input logic                    zero_off,
   input logic [LANES-1:0]        lane_en,
   input logic [LANES*LANE_W-1:0] acc_in,
   input logic                    out_valid,
   input logic [LANES*LANE_W-1:0] result
);
   localparam int VEC_W = LANES * LANE_W;
   localparam int LAST  = LATENCY - 1;

   logic             v_d    [LATENCY];
   logic             hi_d   [LATENCY];
   logic             zero_d [LATENCY];
   logic [LANES-1:0] en_d   [LATENCY];
   logic [VEC_W-1:0] acc_d  [LATENCY];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LATENCY; i++) begin
            v_d[i] <= 1'b0; hi_d[i] <= 1'b0; zero_d[i] <= 1'b0;
            en_d[i] <= '0;  acc_d[i] <= '0;
         end
      end else begin
         v_d[0] <= in_valid; hi_d[0] <= hi_sel; zero_d[0] <= zero_off;
         en_d[0] <= lane_en; acc_d[0] <= acc_in;
         for (int i = 1; i < LATENCY; i++) begin
            v_d[i] <= v_d[i-1]; hi_d[i] <= hi_d[i-1]; zero_d[i] <= zero_d[i-1];
            en_d[i] <= en_d[i-1]; acc_d[i] <= acc_d[i-1];
         end
      end
   end

   // R8
   latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_d[LAST]);

   // R9
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && result == '0));

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
         // R6
         merge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !en_d[LAST][k] && !zero_d[LAST])
            |-> result[k*LANE_W +: LANE_W] == acc_d[LAST][k*LANE_W +: LANE_W]);
         // R7
         zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !en_d[LAST][k] && zero_d[LAST])
            |-> result[k*LANE_W +: LANE_W] == '0);
         // R4
         high_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && en_d[LAST][k] && hi_d[LAST]
             && acc_d[LAST][k*LANE_W +: LANE_W] == '0)
            |-> result[k*LANE_W+OP_W +: PAD_W] == '0);
      end
   endgenerate
endmodule

bind pmac52_unit pmac52_chk #(.LANES(LANES), .LATENCY(LATENCY)) u_chk (.*);

// File: tb/pmac52_unit_test.sv
module pmac52_unit_test;
   localparam int LANES = 3;
   localparam int LAT   = 2;
   localparam int VW    = LANES * 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          hi_sel = 1'b0;
   logic          zero_off = 1'b0;
   logic [LANES-1:0] lane_en = '0;
   logic [VW-1:0] src_a = '0;
   logic [VW-1:0] src_b = '0;
   logic [VW-1:0] acc_in = '0;
   logic          out_valid;
   logic [VW-1:0] result;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   string cur_tag = "R3";

   typedef struct {
      bit            v;
      logic [VW-1:0] d;
      string         tag;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   pmac52_unit #(.LANES(LANES), .LATENCY(LAT)) uut (
      .clk, .rst_n, .in_valid, .hi_sel, .zero_off, .lane_en,
      .src_a, .src_b, .acc_in, .out_valid, .result
   );

   function automatic logic [63:0] ref_lane(logic [63:0] a, logic [63:0] b,
                                            logic [63:0] acc, bit en, bit hi, bit zr);
      logic [127:0] p;
      logic [63:0]  half;
      p = {76'd0, a[51:0]} * {76'd0, b[51:0]};
      half = hi ? {12'd0, p[103:52]} : {12'd0, p[51:0]};
      if (en) return acc + half;
      if (zr) return 64'd0;
      return acc;
   endfunction

   // reference model: one entry per clock edge
   always @(posedge clk) begin
      exp_t e;
      if (!rst_n) begin
         q.delete();
      end else begin
         e.v = in_valid;
         e.tag = cur_tag;
         for (int k = 0; k < LANES; k++)
            e.d[k*64 +: 64] = ref_lane(src_a[k*64 +: 64], src_b[k*64 +: 64],
                                       acc_in[k*64 +: 64], lane_en[k], hi_sel, zero_off);
         q.push_back(e);
         if (q.size() > LAT) void'(q.pop_front());
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit ev;
         ev = (q.size() == LAT) ? q[0].v : 1'b0;
         checks++;
         if (out_valid !== ev) begin
            fails++;
            $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, ev);
         end else if (ev) begin
            for (int k = 0; k < LANES; k++)
               if (result[k*64 +: 64] !== q[0].d[k*64 +: 64]) begin
                  fails++;
                  $display("FAIL %s lane %0d actual=%h expected=%h (R1)",
                           q[0].tag, k, result[k*64 +: 64], q[0].d[k*64 +: 64]);
               end
         end
      end
   end

   task automatic op(string tag, logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] acc,
                     logic [LANES-1:0] en, bit hi, bit zr);
      @(negedge clk);
      cur_tag  = tag;
      in_valid = 1'b1; src_a = a; src_b = b; acc_in = acc;
      lane_en  = en; hi_sel = hi; zero_off = zr;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cur_tag = "R8";
         in_valid = 1'b0;
         src_a = {LANES{64'hdead_beef_0bad_f00d}};
      end
   endtask

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] v;
      for (int k = 0; k < LANES; k++) v[k*64 +: 64] = {$urandom(), $urandom()};
      return v;
   endfunction

   localparam logic [63:0] ONES52 = 64'h000F_FFFF_FFFF_FFFF;
   localparam logic [63:0] JUNK   = 64'hABC0_0000_0000_0000;

   initial begin
      // R9: reset state
      repeat (3) begin
         @(negedge clk);
         checks++;
         if (out_valid !== 1'b0 || result !== '0) begin
            fails++;
            $display("FAIL R9 reset out_valid=%0b result=%h expected 0/0", out_valid, result);
         end
      end
      rst_n = 1'b1;
      idle(2);
      // R3/R4: all-ones fields
      op("R3", {LANES{ONES52}}, {LANES{ONES52}}, '0, '1, 0, 0);
      op("R4", {LANES{ONES52}}, {LANES{ONES52}}, '0, '1, 1, 0);
      // zero operands
      op("R3", '0, {LANES{ONES52}}, {LANES{64'h1234_5678_9abc_def0}}, '1, 0, 0);
      op("R4", '0, '0, {LANES{64'h0000_0000_0000_0007}}, '1, 1, 0);
      // R2: junk above bit 51 must not matter
      op("R2", {LANES{JUNK | 64'd3}}, {LANES{64'hFFF0_0000_0000_0005}}, '0, '1, 0, 0);
      op("R2", {LANES{JUNK | ONES52}}, {LANES{64'hFFF0_0000_0000_0000 | ONES52}}, '0, '1, 1, 0);
      // R5: wrap
      op("R5", {LANES{64'd2}}, {LANES{64'd3}}, {LANES{64'hFFFF_FFFF_FFFF_FFFE}}, '1, 0, 0);
      op("R5", {LANES{ONES52}}, {LANES{ONES52}}, {LANES{64'hFFFF_FFFF_FFFF_FFFF}}, '1, 1, 0);
      idle(1);
      // R6/R7: masking, per-lane distinct data (R1)
      op("R6", rnd_vec(), rnd_vec(), rnd_vec(), 3'b010, 0, 0);
      op("R7", rnd_vec(), rnd_vec(), rnd_vec(), 3'b101, 1, 1);
      op("R6", rnd_vec(), rnd_vec(), rnd_vec(), 3'b000, 0, 0);
      op("R7", rnd_vec(), rnd_vec(), rnd_vec(), 3'b000, 0, 1);
      op("R1", {64'd7, 64'd0, ONES52}, {64'd9, ONES52, ONES52}, {64'd1, 64'd2, 64'd3}, 3'b111, 0, 0);
      idle(3);
      // random, with gaps
      for (int i = 0; i < 400; i++) begin
         op(((i % 2) != 0) ? "R4" : "R3", rnd_vec(), rnd_vec(), rnd_vec(),
            LANES'($urandom()), bit'($urandom() % 2), bit'($urandom() % 2));
         if ($urandom() % 5 == 0) idle(1 + $urandom() % 3);
      end
      idle(LAT + 2);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1;
         fails++;
         $display("FAIL R8 watchdog expired actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule